// File: doc/BRIEF.md
# Two-Stage Fetch Unit with Control-Transfer Kill

This block is the front end of a two-stage, word-addressed 32-bit processor. It holds the program counter and presents it as a 24-bit word address to an instruction memory that answers in the same cycle. It captures the returned word in an instruction register that feeds the execute stage, and it keeps the address of that instruction next to it. Instruction memory starts at word 0, but programs are linked for a byte-addressed text base. Jump targets are therefore rebased by a fixed word offset of 0x100000, and the link value for a call gets the offset added back.

The execute stage decodes the instruction and reports control transfers as plain request pins: a taken branch with its 16-bit offset, a direct jump (also used for jump-and-link) with its 26-bit target field, and a jump through a register with the register's value. When any of these is raised, the instruction being fetched in parallel is on the wrong path. It is replaced by the all-zero nop before it enters execute, and the next fetch starts at the new target. No stall cycle is added.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `imem_addr`, `pc_ex` and `instr_ex` are all zero, so the first instruction executed is a nop.
- R2: With no request raised, the next fetch address is the current one plus 1 (modulo 2^24). At the same edge `instr_ex` takes the word on `imem_rdata` and `pc_ex` takes the address that word was fetched from.
- R3: A raised `branch_taken` sets the next fetch address to `pc_ex` + 1 + the sign-extended `branch_offset`, modulo 2^24.
- R4: With `branch_taken` low, `branch_offset` has no effect: fetch continues sequentially and the fetched word reaches `instr_ex` unchanged.
- R5: A raised `jump` sets the next fetch address to `jump_target[23:0]` − 0x100000 modulo 2^24. Bits 25:24 of the target field are ignored and no low-order zeros are appended.
- R6: A raised `jr` sets the next fetch address to `jr_value[23:0]` − 0x100000 modulo 2^24. Bits 31:24 of the value are ignored.
- R7: `link_value` is (`pc_ex` + 1 + 0x100000) modulo 2^24, zero-extended to 32 bits.
- R8: When several requests are raised together, `jr` wins over `jump`, and `jump` wins over `branch_taken`.
- R9: In the cycle after any request, `instr_ex` is 0x00000000. The fetch after the redirect reads the target plus 1, with no stall cycle.
- R10: A taken branch with offset −1 (0xFFFF) that is repeated whenever it reaches execute keeps `pc_ex` at the branch's own address each time it executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_rdata | input | 32 | Word returned by instruction memory for `imem_addr` in the same cycle |
| branch_taken | input | 1 | Execute resolved a taken conditional branch |
| branch_offset | input | 16 | Signed word offset of that branch |
| jump | input | 1 | Execute holds a direct jump or jump-and-link |
| jump_target | input | 26 | Target field of the direct jump |
| jr | input | 1 | Execute holds a jump through a register |
| jr_value | input | 32 | Register value for that jump, a word address |
| imem_addr | output | 24 | Word address being fetched (the PC) |
| instr_ex | output | 32 | Instruction presented to execute |
| pc_ex | output | 24 | Word address of `instr_ex` |
| link_value | output | 32 | Return address to write to register 31 on jump-and-link |

## Verification
Two functions can meet in one cycle. The kill can fall on a slot that already holds a nop, and a redirect can arrive in the same cycle as a competing request. The stimulus table raises a register jump while execute holds a killed nop. It also raises a branch together with a jump, and all three requests together. The expected fetch address is worked out from the priority order, and the expected instruction must still be zero in the following cycle. A self-looping branch and targets that wrap around 2^24 during rebasing are judged in the same way.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int unsigned ADDR_W = 24;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFF_W  = 16;
    localparam int unsigned TGT_W  = 26;

    localparam logic [ADDR_W-1:0] DEFAULT_TEXT_BASE = 24'h100000;
    localparam logic [WORD_W-1:0] NOP_WORD          = '0;

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_JUMP   = 2'd2,
        SEL_JREG   = 2'd3
    } pc_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] pc_ex;
        logic [WORD_W-1:0] ir;
    } fetch_state_t;

endpackage

// File: rtl/fetch_redirect_arb.sv
module fetch_redirect_arb
    import fetch_pkg::*;
(
    input  logic    branch_taken,
    input  logic    jump,
    input  logic    jr,
    output pc_sel_e sel,
    output logic    kill
);

    always_comb begin
        if (jr) begin
            sel = SEL_JREG;
        end else if (jump) begin
            sel = SEL_JUMP;
        end else if (branch_taken) begin
            sel = SEL_BRANCH;
        end else begin
            sel = SEL_SEQ;
        end
        kill = (sel != SEL_SEQ);
    end

endmodule

// File: rtl/fetch_target_calc.sv
module fetch_target_calc
    import fetch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TEXT_BASE = DEFAULT_TEXT_BASE
) (
    input  pc_sel_e           sel,
    input  logic [ADDR_W-1:0] pc_fetch,
    input  logic [ADDR_W-1:0] pc_exec,
    input  logic [OFF_W-1:0]  offset,
    input  logic [TGT_W-1:0]  target_field,
    input  logic [WORD_W-1:0] reg_value,
    output logic [ADDR_W-1:0] next_pc
);

    localparam int unsigned EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] branch_pc;
    logic [ADDR_W-1:0] jump_pc;
    logic [ADDR_W-1:0] jreg_pc;
    logic [ADDR_W-1:0] offset_ext;

    always_comb begin
        offset_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        seq_pc     = pc_fetch + ADDR_W'(1);
        branch_pc  = pc_exec + ADDR_W'(1) + offset_ext;
        jump_pc    = target_field[ADDR_W-1:0] - TEXT_BASE;
        jreg_pc    = reg_value[ADDR_W-1:0] - TEXT_BASE;
        unique case (sel)
            SEL_BRANCH: next_pc = branch_pc;
            SEL_JUMP:   next_pc = jump_pc;
            SEL_JREG:   next_pc = jreg_pc;
            default:    next_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/fetch_link_gen.sv
module fetch_link_gen
    import fetch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TEXT_BASE = DEFAULT_TEXT_BASE
) (
    input  logic [ADDR_W-1:0] pc_exec,
    output logic [WORD_W-1:0] link
);

    localparam int unsigned PAD_W = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] ret_addr;

    always_comb begin
        ret_addr = pc_exec + ADDR_W'(1) + TEXT_BASE;
        link     = {{PAD_W{1'b0}}, ret_addr};
    end

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
    import fetch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TEXT_BASE = DEFAULT_TEXT_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] imem_rdata,
    input  logic              branch_taken,
    input  logic [OFF_W-1:0]  branch_offset,
    input  logic              jump,
    input  logic [TGT_W-1:0]  jump_target,
    input  logic              jr,
    input  logic [WORD_W-1:0] jr_value,
    output logic [ADDR_W-1:0] imem_addr,
    output logic [WORD_W-1:0] instr_ex,
    output logic [ADDR_W-1:0] pc_ex,
    output logic [WORD_W-1:0] link_value
);

    fetch_state_t      state_d;
    fetch_state_t      state_q;
    pc_sel_e           sel;
    logic              kill;
    logic [ADDR_W-1:0] next_pc;

    fetch_redirect_arb i_arb (
        .branch_taken (branch_taken),
        .jump         (jump),
        .jr           (jr),
        .sel          (sel),
        .kill         (kill)
    );

    fetch_target_calc #(
        .TEXT_BASE (TEXT_BASE)
    ) i_target (
        .sel          (sel),
        .pc_fetch     (state_q.pc),
        .pc_exec      (state_q.pc_ex),
        .offset       (branch_offset),
        .target_field (jump_target),
        .reg_value    (jr_value),
        .next_pc      (next_pc)
    );

    fetch_link_gen #(
        .TEXT_BASE (TEXT_BASE)
    ) i_link (
        .pc_exec (state_q.pc_ex),
        .link    (link_value)
    );

    always_comb begin
        state_d       = state_q;
        state_d.pc    = next_pc;
        state_d.pc_ex = state_q.pc;
        state_d.ir    = kill ? NOP_WORD : imem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign imem_addr = state_q.pc;
    assign instr_ex  = state_q.ir;
    assign pc_ex     = state_q.pc_ex;

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk
    import fetch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TEXT_BASE = DEFAULT_TEXT_BASE
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] imem_rdata,
    input logic              branch_taken,
    input logic [OFF_W-1:0]  branch_offset,
    input logic              jump,
    input logic [TGT_W-1:0]  jump_target,
    input logic              jr,
    input logic [WORD_W-1:0] jr_value,
    input logic [ADDR_W-1:0] imem_addr,
    input logic [WORD_W-1:0] instr_ex,
    input logic [ADDR_W-1:0] pc_ex
);

    logic any_req;
    assign any_req = branch_taken | jump | jr;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && pc_ex == '0 && instr_ex == '0));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        !any_req |=> (imem_addr == $past(imem_addr) + ADDR_W'(1)
                      && instr_ex == $past(imem_rdata)));

    p_pc_follows_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_ex == $past(imem_addr));

    p_branch_dest_r3: assert property (@(posedge clk) disable iff (rst)
        (branch_taken && !jump && !jr) |=>
            imem_addr == $past(pc_ex) + ADDR_W'(1)
                         + {{(ADDR_W-OFF_W){$past(branch_offset[OFF_W-1])}}, $past(branch_offset)});

    p_jump_dest_r5: assert property (@(posedge clk) disable iff (rst)
        (jump && !jr) |=> imem_addr == $past(jump_target[ADDR_W-1:0]) - TEXT_BASE);

    p_jreg_dest_r6: assert property (@(posedge clk) disable iff (rst)
        jr |=> imem_addr == $past(jr_value[ADDR_W-1:0]) - TEXT_BASE);

    p_squash_r9: assert property (@(posedge clk) disable iff (rst)
        any_req |=> instr_ex == NOP_WORD);

endmodule

bind fetch_unit fetch_unit_chk #(.TEXT_BASE(TEXT_BASE)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .imem_rdata    (imem_rdata),
    .branch_taken  (branch_taken),
    .branch_offset (branch_offset),
    .jump          (jump),
    .jump_target   (jump_target),
    .jr            (jr),
    .jr_value      (jr_value),
    .imem_addr     (imem_addr),
    .instr_ex      (instr_ex),
    .pc_ex         (pc_ex)
);

// File: tb/test_fetch_unit.sv
module test_fetch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_rdata;
    logic        branch_taken = 1'b0;
    logic [15:0] branch_offset = '0;
    logic        jump = 1'b0;
    logic [25:0] jump_target = '0;
    logic        jr = 1'b0;
    logic [31:0] jr_value = '0;
    logic [23:0] imem_addr;
    logic [31:0] instr_ex;
    logic [23:0] pc_ex;
    logic [31:0] link_value;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    // Instruction memory model: every word is tagged with its own address.
    assign imem_rdata = {8'h5A, imem_addr};

    fetch_unit i_fetch_unit (
        .clk           (clk),
        .rst           (rst),
        .imem_rdata    (imem_rdata),
        .branch_taken  (branch_taken),
        .branch_offset (branch_offset),
        .jump          (jump),
        .jump_target   (jump_target),
        .jr            (jr),
        .jr_value      (jr_value),
        .imem_addr     (imem_addr),
        .instr_ex      (instr_ex),
        .pc_ex         (pc_ex),
        .link_value    (link_value)
    );

    typedef struct packed {
        logic        br;
        logic [15:0] off;
        logic        jmp;
        logic [25:0] tgt;
        logic        jreg;
        logic [31:0] jrv;
        logic [23:0] e_addr;
        logic [31:0] e_instr;
        logic [23:0] e_pcex;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000000, 32'h00000000, 24'h000000, 4'd1},  // R1 reset state
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000001, 32'h5A000000, 24'h000000, 4'd2},  // R2
        '{1'b1, 16'h0005, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000002, 32'h5A000001, 24'h000001, 4'd2},  // R3 branch +5
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000007, 32'h00000000, 24'h000002, 4'd3},  // R3 R9
        '{1'b0, 16'h0003, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000008, 32'h5A000007, 24'h000007, 4'd9},  // R9 no stall, R4 offset set
        '{1'b0, 16'h0000, 1'b1, 26'h0400010, 1'b0, 32'h0,        24'h000009, 32'h5A000008, 24'h000008, 4'd4},  // R4 ignored
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'h300010, 32'h00000000, 24'h000009, 4'd5},  // R5
        '{1'b0, 16'h0000, 1'b1, 26'h0100020, 1'b0, 32'h0,        24'h300011, 32'h5A300010, 24'h300010, 4'd7},  // R7 link 0x400011
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b1, 32'h00100005, 24'h000020, 32'h00000000, 24'h300011, 4'd5},  // R5 jal dest
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000005, 32'h00000000, 24'h000020, 4'd6},  // R6
        '{1'b1, 16'hFFFF, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000006, 32'h5A000005, 24'h000005, 4'd10}, // R10 loop
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000005, 32'h00000000, 24'h000006, 4'd10}, // R10
        '{1'b1, 16'hFFFF, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000006, 32'h5A000005, 24'h000005, 4'd10}, // R10 same pc
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b1, 32'hAB000003, 24'h000005, 32'h00000000, 24'h000006, 4'd10}, // R10, jr on nop slot
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'hF00003, 32'h00000000, 24'h000005, 4'd6},  // R6 wrap, upper bits ignored
        '{1'b0, 16'h0000, 1'b1, 26'h3FFFFFF, 1'b0, 32'h0,        24'hF00004, 32'h5AF00003, 24'hF00003, 4'd7},  // R7 link wraps to 4
        '{1'b1, 16'h0005, 1'b1, 26'h0100000, 1'b0, 32'h0,        24'hEFFFFF, 32'h00000000, 24'hF00004, 4'd5},  // R5 top bits ignored
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000000, 32'h00000000, 24'hEFFFFF, 4'd8},  // R8 jump over branch
        '{1'b1, 16'h0007, 1'b1, 26'h0100002, 1'b1, 32'h00100009, 24'h000001, 32'h5A000000, 24'h000000, 4'd2},  // R2
        '{1'b0, 16'h0000, 1'b0, 26'h0,       1'b0, 32'h0,        24'h000009, 32'h00000000, 24'h000001, 4'd8}   // R8 jr wins
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic set_req(input vec_t v);
        branch_taken  = v.br;
        branch_offset = v.off;
        jump          = v.jmp;
        jump_target   = v.tgt;
        jr            = v.jreg;
        jr_value      = v.jrv;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "addr in reset", {8'h0, imem_addr}, 32'h0);
        check("R1", "instr in reset", instr_ex, 32'h0);
        rst = 1'b0;

        // Expected link: (pc_ex + 1 + 0x100000) mod 2^24, zero-extended (R7).
        for (int i = 0; i < NV; i++) begin
            string tag;
            logic [23:0] e_link;
            tag    = $sformatf("R%0d step %0d", VECS[i].req, i);
            e_link = VECS[i].e_pcex + 24'h000001 + 24'h100000;
            check(tag, "imem_addr", {8'h0, imem_addr}, {8'h0, VECS[i].e_addr});
            check(tag, "instr_ex", instr_ex, VECS[i].e_instr);
            check(tag, "pc_ex", {8'h0, pc_ex}, {8'h0, VECS[i].e_pcex});
            check(tag, "link_value R7", link_value, {8'h0, e_link});
            set_req(VECS[i]);
            @(negedge clk);
        end

        // Directed: reset in the middle of a run clears everything (R1).
        set_req('0);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "addr after mid reset", {8'h0, imem_addr}, 32'h0);
        check("R1", "pc_ex after mid reset", {8'h0, pc_ex}, 32'h0);
        check("R1", "instr after mid reset", instr_ex, 32'h0);
        @(negedge clk);
        check("R2", "first fetch word", instr_ex, 32'h5A000000);
        check("R2", "second address", {8'h0, imem_addr}, 32'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule